// File: doc/BRIEF.md
# Cascadable synchronous binary counter

This block is a small up counter. Its width is a parameter and defaults to four bits. All state bits load, clear or advance together on the rising clock edge. A low on the active-low load input copies the data inputs into the counter. Counting needs two enables: a parallel enable and a trickle enable. The trickle enable also gates the terminal-count output, which is high while the count is all ones.

A build-time parameter picks the clear style. The clear can act at once, with no clock (asynchronous), or at the next rising edge (synchronous). In both styles the clear outranks load and count. When no clear applies, load outranks count, and count outranks hold.

Wide counters are built by chaining stages. Each stage's terminal-count output drives the next stage's trickle enable, and every parallel enable is tied to one shared enable. The terminal-count output is combinational, so a chained stage sees it in the same cycle. With the synchronous clear, a shorter count cycle can be made by decoding a chosen state outside the block and feeding that decode to the clear input.

Top module: `cascade_counter`

## Requirements
- R1: With `load_n` high, no clear active, and both `en_par` and `en_trk` high, `q` increases by one at each rising edge.
- R2: With no clear active, `load_n` low at a rising edge copies `din` into `q`, whatever the levels of `en_par` and `en_trk`.
- R3: When `ASYNC_CLR` is 1, `clr_n` low forces `q` to zero at once, without waiting for a clock edge, and holds it there.
- R4: When `ASYNC_CLR` is 0, `clr_n` low clears `q` to zero at the next rising edge, over load and both enables. Before that edge, `q` is unchanged.
- R5: With `load_n` high and either enable low, `q` holds its value across the edge.
- R6: `tc` is high exactly when `en_trk` is high and `q` is all ones. It follows its inputs in the same cycle, with no register.
- R7: From all ones, an enabled count wraps `q` to zero.
- R8: In a chain where each stage's `tc` drives the next stage's `en_trk`, and all `en_par` share one enable, the stages count together as one binary counter with the combined width. This includes carries across stage boundaries and the final wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous according to `ASYNC_CLR` |
| load_n | input | 1 | Active-low parallel load |
| din | input | WIDTH | Data loaded when `load_n` is low |
| en_par | input | 1 | Parallel count enable |
| en_trk | input | 1 | Trickle count enable; also gates `tc` |
| q | output | WIDTH | Registered count |
| tc | output | 1 | Terminal count: `en_trk` and all ones |

## Verification
Two three-stage chains, one per clear style, receive the same stimulus and are compared with a 12-bit reference model. The stimulus includes plain runs of counting, which catch errors in the carry between stages and in the wrap. It includes loads made with the enable high and with it low, which show whether load truly outranks count, and holds, which show up any stray increment. A clear raised together with load and enable tests the clear's priority. A clear dropped in the middle of a cycle tells the two styles apart: the asynchronous chain must read zero at once, while the synchronous chain keeps its value until the next edge. The terminal-count output of the last stage is checked both at all ones with the enable high and with the enable low.

// File: rtl/ccnt_pkg.sv
package ccnt_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_COUNT = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } ccnt_act_e;
endpackage

// File: rtl/ccnt_ctrl.sv
module ccnt_ctrl
  import ccnt_pkg::*;
#(
  parameter bit SYNC_CLR = 1'b0
) (
  input  logic      clr_n,
  input  logic      load_n,
  input  logic      en_par,
  input  logic      en_trk,
  output ccnt_act_e act
);
  // Priority: clear (sync style only), then load, then count, then hold.
  always_comb begin
    if (SYNC_CLR && !clr_n)  act = ACT_CLEAR;
    else if (!load_n)        act = ACT_LOAD;
    else if (en_par && en_trk) act = ACT_COUNT;
    else                     act = ACT_HOLD;
  end
endmodule

// File: rtl/ccnt_state.sv
module ccnt_state
  import ccnt_pkg::*;
#(
  parameter int unsigned WIDTH     = 4,
  parameter bit          ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  ccnt_act_e        act,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    case (act)
      ACT_CLEAR: q_nxt = '0;
      ACT_LOAD:  q_nxt = din;
      ACT_COUNT: q_nxt = q_r + ONE;
      default:   q_nxt = q_r;
    endcase
  end

  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q_r <= '0;
        else        q_r <= q_nxt;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        q_r <= q_nxt;
      end
    end
  endgenerate

  assign q = q_r;
endmodule

// File: rtl/ccnt_tc.sv
module ccnt_tc #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             en_trk,
  output logic             tc
);
  assign tc = en_trk & (&q);
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
  import ccnt_pkg::*;
#(
  parameter int unsigned WIDTH     = 4,
  parameter bit          ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             en_par,
  input  logic             en_trk,
  output logic [WIDTH-1:0] q,
  output logic             tc
);
  ccnt_act_e act;

  ccnt_ctrl #(.SYNC_CLR(!ASYNC_CLR)) u_ctrl (
    .clr_n (clr_n),
    .load_n(load_n),
    .en_par(en_par),
    .en_trk(en_trk),
    .act   (act)
  );

  ccnt_state #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_state (
    .clk  (clk),
    .clr_n(clr_n),
    .act  (act),
    .din  (din),
    .q    (q)
  );

  ccnt_tc #(.WIDTH(WIDTH)) u_tc (
    .q     (q),
    .en_trk(en_trk),
    .tc    (tc)
  );

  // R2: load copies data regardless of enables
  p_load_r2: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(din));

  // R1: both enables high advance by one
  p_count_r1: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_par && en_trk) |=> q == WIDTH'($past(q) + 1'b1));

  // R5: hold when an enable is low
  p_hold_r5: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_par && en_trk)) |=> q == $past(q));

  // R7: all ones wraps to zero on count
  p_wrap_r7: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_par && en_trk && (&q)) |=> q == '0);

  // R6: terminal count only at all ones with trickle enable
  p_tc_r6: assert property (@(posedge clk) disable iff (!clr_n)
    tc |-> (en_trk && (&q)));

  generate
    if (ASYNC_CLR) begin : g_chk_async
      // R3: clear holds the count at zero with no edge needed
      p_clear_async_r3: assert property (@(posedge clk)
        !clr_n |-> q == '0);
    end else begin : g_chk_sync
      // R4: clear takes effect at the next edge
      p_clear_sync_r4: assert property (@(posedge clk)
        !clr_n |=> q == '0);
    end
  endgenerate
endmodule

// File: tb/cascade_counter_bench.sv
module cascade_counter_bench;
  localparam int W      = 4;
  localparam int STAGES = 3;
  localparam int TOT    = W * STAGES;

  logic           clk = 1'b0;
  logic           clr_n = 1'b0;
  logic           load_n = 1'b1;
  logic [TOT-1:0] din = '0;
  logic           en = 1'b0;

  logic [TOT-1:0]    qa, qs;
  logic [STAGES:0]   chain_a, chain_s;

  always #10 clk = ~clk;

  assign chain_a[0] = en;
  assign chain_s[0] = en;

  for (genvar s = 0; s < STAGES; s++) begin : gasync
    cascade_counter #(.WIDTH(W), .ASYNC_CLR(1'b1)) u_cascade_counter (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din[s*W +: W]),
      .en_par(en), .en_trk(chain_a[s]), .q(qa[s*W +: W]), .tc(chain_a[s+1]));
  end

  for (genvar s = 0; s < STAGES; s++) begin : gsync
    cascade_counter #(.WIDTH(W), .ASYNC_CLR(1'b0)) u_cascade_counter (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din[s*W +: W]),
      .en_par(en), .en_trk(chain_s[s]), .q(qs[s*W +: W]), .tc(chain_s[s+1]));
  end

  typedef struct {
    logic [TOT-1:0] q;
    logic           tc;
    string          tag;
  } exp_t;

  exp_t           exp_q[$];
  logic [TOT-1:0] model = '0;
  int             n_chk = 0;
  int             n_bad = 0;
  bit             done  = 1'b0;

  task automatic check(input string tag, input string what,
                       input logic [TOT-1:0] act, input logic [TOT-1:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // Driver: apply one vector before an edge and push the expected result.
  task automatic apply(input logic c, input logic l, input logic [TOT-1:0] d,
                       input logic e, input string tag);
    exp_t x;
    @(negedge clk);
    clr_n = c; load_n = l; din = d; en = e;
    if (!c)      model = '0;
    else if (!l) model = d;
    else if (e)  model = model + 1'b1;
    x.q = model;
    x.tc = e && (model == {TOT{1'b1}});
    x.tag = tag;
    exp_q.push_back(x);
  endtask

  // Monitor: compare after each edge.
  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      exp_t x;
      x = exp_q.pop_front();
      check(x.tag, "async chain q", qa, x.q);
      check(x.tag, "sync chain q", qs, x.q);
      check("R6", "async chain tc", {{(TOT-1){1'b0}}, chain_a[STAGES]}, {{(TOT-1){1'b0}}, x.tc});
      check("R6", "sync chain tc", {{(TOT-1){1'b0}}, chain_s[STAGES]}, {{(TOT-1){1'b0}}, x.tc});
    end
  end

  // Clear dropped mid-cycle: async clears at once, sync waits for the edge.
  task automatic mid_clear();
    @(posedge clk);
    #8;
    clr_n = 1'b0;
    #1;
    check("R3", "async q right after clear", qa, '0);
    check("R4", "sync q before edge", qs, model);
    apply(1'b0, 1'b1, '0, 1'b1, "R4");
  endtask

  initial begin
    apply(1'b0, 1'b1, '0, 1'b0, "R3");
    apply(1'b0, 1'b1, '0, 1'b1, "R4");
    for (int i = 0; i < 20; i++) apply(1'b1, 1'b1, '0, 1'b1, "R1");
    for (int i = 0; i < 3; i++)  apply(1'b1, 1'b1, '0, 1'b0, "R5");
    apply(1'b1, 1'b0, 12'h0FE, 1'b0, "R2");
    for (int i = 0; i < 3; i++)  apply(1'b1, 1'b1, '0, 1'b1, "R8");
    apply(1'b1, 1'b0, 12'hFFD, 1'b1, "R2");
    apply(1'b1, 1'b1, '0, 1'b1, "R1");
    apply(1'b1, 1'b1, '0, 1'b1, "R6");
    apply(1'b1, 1'b1, '0, 1'b1, "R7");
    apply(1'b1, 1'b0, 12'hFFF, 1'b0, "R6");
    apply(1'b1, 1'b0, 12'hFFF, 1'b1, "R6");
    apply(1'b0, 1'b0, 12'h123, 1'b1, "R4");
    for (int i = 0; i < 5; i++)  apply(1'b1, 1'b1, '0, 1'b1, "R1");
    apply(1'b1, 1'b0, 12'h5A5, 1'b1, "R2");
    mid_clear();
    apply(1'b1, 1'b0, 12'h7E0, 1'b0, "R2");
    for (int i = 0; i < 40; i++) apply(1'b1, 1'b1, '0, 1'b1, "R8");
    apply(1'b1, 1'b0, 12'hF00, 1'b1, "R2");
    for (int i = 0; i < 300; i++) apply(1'b1, 1'b1, '0, (i % 7) != 3, "R8");
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule